// File: doc/BRIEF.md
# Management Serial Port Slave

This block is the PHY-side end of a two-wire management link. It is clocked by the management clock, samples the shared data line on every rising edge, and holds a small file of 16-bit registers that a station manager reads and writes by sending serial frames to the configured port address. It also controls the data line's output enable: the manager drives the line for most of a frame, and the block drives it only while it returns read data.

The block must see at least `PRE_LEN` consecutive ones before it accepts a frame. It then expects a start code, an opcode, a 5-bit port address, a 5-bit register address, a two-bit turnaround and a 16-bit data field. On a write it updates the addressed register after the last data bit. On a read it takes the line in the second turnaround bit and shifts the register out MSB first. After each frame it looks for a fresh preamble. Register 18 latches event inputs and clears when it is read. Register 19 masks those bits from the interrupt output.

Top module: `mdio_slave`

## Requirements
- R1: After reset, mdio_oe_o is 0, irq_o is 0, ctrl_o equals CTRL_RST (default 16'h3000), adv_o equals ADV_RST (default 16'h01E1), and the mask register reads 16'hFFFF.
- R2: A frame is accepted only after at least PRE_LEN (default 32) consecutive 1 bits have been sampled. A start bit that follows a shorter run of ones is ignored, so nothing is written and the line is not driven.
- R3: The start code must be 0 then 1. The opcode, sent first bit first, is 1,0 for a read and 0,1 for a write. Any other start code or opcode drops the frame, and a new full preamble is then needed.
- R4: On a write frame, the 16 data bits are sampled on rising clock edges MSB first. They are stored in the addressed register when the last data bit is sampled.
- R5: On a read frame, the block leaves the line undriven during the first turnaround bit. Just after the rising edge that samples that bit, it enables the output with the value 0.
- R6: Read data is driven MSB first, and each bit changes just after a rising edge. The output enable drops just after the rising edge on which the 16th data bit period ends.
- R7: When the port address does not equal phy_addr_i, the block never drives the line, writes nothing and clears nothing. It still follows the frame to its end.
- R8: Register map: 0 is control (read/write, on ctrl_o), 1 is status (read-only, status_i), 2 and 3 are identifier constants ID_HI and ID_LO, 4 is advertisement (read/write, on adv_o) and 5 is link partner (read-only, partner_i). Other addresses read 0 and ignore writes, as do writes to read-only registers.
- R9: Register 18 sets bit k on any clock edge where event_i[k] is 1, and it is cleared by a matching read. An event present on the clock edge of the read keeps its bit set.
- R10: Register 19 is read/write, and a 1 bit masks the interrupt. irq_o is 1 exactly when some bit of register 18 is set whose mask bit is 0.
- R11: After any frame ends, the block again requires a full preamble. A frame sent straight after the previous one is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc_i | input | 1 | Management clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mdio_i | input | 1 | Sampled level of the shared data line |
| mdio_o | output | 1 | Data driven onto the line |
| mdio_oe_o | output | 1 | Output enable for the line |
| phy_addr_i | input | 5 | Port address this block answers to |
| status_i | input | 16 | Value returned for register 1 |
| partner_i | input | 16 | Value returned for register 5 |
| event_i | input | 16 | Event bits latched into register 18 |
| ctrl_o | output | 16 | Control register contents |
| adv_o | output | 16 | Advertisement register contents |
| irq_o | output | 1 | Unmasked latched event present |

## Verification
The hardest condition to reach is an event that arrives on the same clock edge as the read that clears register 18. The bench holds the event bit high for the whole read frame, so that edge is covered whatever its exact position. It then drops the event and reads the register again to show that the bit survived. A second hard condition is a start bit after exactly one one too few. The bench first sends a single zero to empty the ones count, then sends 31 ones, and only then sends a complete write frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int DW = 16;
  localparam int AW = 5;

  typedef enum logic [2:0] {S_PRE, S_ST, S_OP, S_ADR, S_TA, S_DAT} mdio_state_e;

  localparam logic [AW-1:0] A_CTRL  = 5'd0;
  localparam logic [AW-1:0] A_STAT  = 5'd1;
  localparam logic [AW-1:0] A_ID_HI = 5'd2;
  localparam logic [AW-1:0] A_ID_LO = 5'd3;
  localparam logic [AW-1:0] A_ADV   = 5'd4;
  localparam logic [AW-1:0] A_PART  = 5'd5;
  localparam logic [AW-1:0] A_INT   = 5'd18;
  localparam logic [AW-1:0] A_MASK  = 5'd19;

  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;
endpackage

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mdio_i,
  input  logic [AW-1:0] phy_addr_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          rd_req_o,
  output logic          wr_req_o,
  output logic [AW-1:0] reg_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          mdio_o,
  output logic          mdio_oe_o
);
  localparam int OW = $clog2(PRE_LEN + 1);
  localparam logic [OW-1:0] PRE_MAX = OW'(PRE_LEN);
  localparam int ADR_BITS = 2 * AW;

  mdio_state_e     state_q;
  logic [OW-1:0]   ones_q;
  logic [3:0]      cnt_q;
  logic            rd_q, match_q, oe_q, out_q;
  logic [ADR_BITS-2:0] adr_q;
  logic [AW-1:0]   ra_q;
  logic [DW-2:0]   din_q;
  logic [DW-1:0]   dout_q;

  assign rd_req_o   = (state_q == S_TA) && (cnt_q == 4'd0) && rd_q && match_q;
  assign wr_req_o   = (state_q == S_DAT) && (cnt_q == 4'(DW-1)) && !rd_q && match_q;
  assign wr_data_o  = {din_q, mdio_i};
  assign reg_addr_o = ra_q;
  assign mdio_o     = out_q;
  assign mdio_oe_o  = oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_PRE;
      ones_q  <= '0;
      cnt_q   <= '0;
      rd_q    <= 1'b0;
      match_q <= 1'b0;
      adr_q   <= '0;
      ra_q    <= '0;
      din_q   <= '0;
      dout_q  <= '0;
      oe_q    <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      case (state_q)
        S_PRE: begin
          if (mdio_i) begin
            if (ones_q != PRE_MAX) ones_q <= ones_q + 1'b1;
          end else begin
            ones_q <= '0;
            if (ones_q == PRE_MAX) state_q <= S_ST;
          end
        end
        S_ST: begin
          cnt_q   <= '0;
          state_q <= mdio_i ? S_OP : S_PRE;
        end
        S_OP: begin
          if (cnt_q == 4'd0) begin
            rd_q  <= mdio_i;
            cnt_q <= 4'd1;
          end else begin
            cnt_q <= '0;
            if ({rd_q, mdio_i} == OP_RD) begin
              rd_q <= 1'b1; state_q <= S_ADR;
            end else if ({rd_q, mdio_i} == OP_WR) begin
              rd_q <= 1'b0; state_q <= S_ADR;
            end else begin
              state_q <= S_PRE;
            end
          end
        end
        S_ADR: begin
          adr_q <= {adr_q[ADR_BITS-3:0], mdio_i};
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == 4'(ADR_BITS-1)) begin
            cnt_q   <= '0;
            ra_q    <= {adr_q[AW-2:0], mdio_i};
            match_q <= (adr_q[ADR_BITS-2:AW-1] == phy_addr_i);
            state_q <= S_TA;
          end
        end
        S_TA: begin
          if (cnt_q == 4'd0) begin
            cnt_q <= 4'd1;
            if (rd_q && match_q) begin
              oe_q   <= 1'b1;
              out_q  <= 1'b0;
              dout_q <= rd_data_i;
            end else begin
              dout_q <= '0;
            end
          end else begin
            out_q   <= dout_q[DW-1];
            dout_q  <= dout_q << 1;
            cnt_q   <= '0;
            state_q <= S_DAT;
          end
        end
        S_DAT: begin
          din_q  <= {din_q[DW-3:0], mdio_i};
          out_q  <= dout_q[DW-1];
          dout_q <= dout_q << 1;
          cnt_q  <= cnt_q + 1'b1;
          if (cnt_q == 4'(DW-1)) begin
            oe_q    <= 1'b0;
            ones_q  <= '0;
            cnt_q   <= '0;
            state_q <= S_PRE;
          end
        end
        default: state_q <= S_PRE;
      endcase
    end
  end

  assert_short_preamble_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_PRE && !mdio_i && ones_q != PRE_MAX) |=> state_q == S_PRE);
  assert_start_code_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_ST && !mdio_i) |=> state_q == S_PRE);
  assert_ta_drive_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mdio_oe_o) |-> !mdio_o);
  assert_oe_in_frame_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdio_oe_o |-> (state_q == S_TA || state_q == S_DAT));
  assert_no_drive_mismatch_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_TA && !match_q) |=> !mdio_oe_o);
endmodule

// File: rtl/mdio_regfile.sv
module mdio_regfile
  import mdio_pkg::*;
#(
  parameter logic [DW-1:0] ID_HI    = 16'h0A5C,
  parameter logic [DW-1:0] ID_LO    = 16'h3E11,
  parameter logic [DW-1:0] CTRL_RST = 16'h3000,
  parameter logic [DW-1:0] ADV_RST  = 16'h01E1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_req_i,
  input  logic          wr_req_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] rd_data_o,
  input  logic [DW-1:0] status_i,
  input  logic [DW-1:0] partner_i,
  input  logic [DW-1:0] event_i,
  output logic [DW-1:0] ctrl_o,
  output logic [DW-1:0] adv_o,
  output logic          irq_o
);
  logic [DW-1:0] ctrl_q, adv_q, int_q, mask_q;
  logic          int_clr;

  assign int_clr = rd_req_i && (addr_i == A_INT);

  always_comb begin
    case (addr_i)
      A_CTRL:  rd_data_o = ctrl_q;
      A_STAT:  rd_data_o = status_i;
      A_ID_HI: rd_data_o = ID_HI;
      A_ID_LO: rd_data_o = ID_LO;
      A_ADV:   rd_data_o = adv_q;
      A_PART:  rd_data_o = partner_i;
      A_INT:   rd_data_o = int_q;
      A_MASK:  rd_data_o = mask_q;
      default: rd_data_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST;
      adv_q  <= ADV_RST;
      mask_q <= '1;
      int_q  <= '0;
    end else begin
      if (wr_req_i && addr_i == A_CTRL) ctrl_q <= wr_data_i;
      if (wr_req_i && addr_i == A_ADV)  adv_q  <= wr_data_i;
      if (wr_req_i && addr_i == A_MASK) mask_q <= wr_data_i;
      int_q <= (int_clr ? '0 : int_q) | event_i;
    end
  end

  assign ctrl_o = ctrl_q;
  assign adv_o  = adv_q;
  assign irq_o  = |(int_q & ~mask_q);

  assert_event_latch_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|event_i) |=> ((int_q & $past(event_i)) == $past(event_i)));
  assert_clear_on_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_clr && event_i == '0) |=> (int_q == '0 && !irq_o));
endmodule

// File: rtl/mdio_slave.sv
module mdio_slave
  import mdio_pkg::*;
#(
  parameter int             PRE_LEN  = 32,
  parameter logic [DW-1:0]  ID_HI    = 16'h0A5C,
  parameter logic [DW-1:0]  ID_LO    = 16'h3E11,
  parameter logic [DW-1:0]  CTRL_RST = 16'h3000,
  parameter logic [DW-1:0]  ADV_RST  = 16'h01E1
) (
  input  logic          mdc_i,
  input  logic          rst_ni,
  input  logic          mdio_i,
  output logic          mdio_o,
  output logic          mdio_oe_o,
  input  logic [AW-1:0] phy_addr_i,
  input  logic [DW-1:0] status_i,
  input  logic [DW-1:0] partner_i,
  input  logic [DW-1:0] event_i,
  output logic [DW-1:0] ctrl_o,
  output logic [DW-1:0] adv_o,
  output logic          irq_o
);
  logic          rd_req, wr_req;
  logic [AW-1:0] reg_addr;
  logic [DW-1:0] wr_data, rd_data;

  mdio_frame #(.PRE_LEN(PRE_LEN)) i_frame (
    .clk_i(mdc_i), .rst_ni(rst_ni), .mdio_i(mdio_i), .phy_addr_i(phy_addr_i),
    .rd_data_i(rd_data), .rd_req_o(rd_req), .wr_req_o(wr_req),
    .reg_addr_o(reg_addr), .wr_data_o(wr_data),
    .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o)
  );

  mdio_regfile #(.ID_HI(ID_HI), .ID_LO(ID_LO), .CTRL_RST(CTRL_RST), .ADV_RST(ADV_RST)) i_regs (
    .clk_i(mdc_i), .rst_ni(rst_ni), .rd_req_i(rd_req), .wr_req_i(wr_req),
    .addr_i(reg_addr), .wr_data_i(wr_data), .rd_data_o(rd_data),
    .status_i(status_i), .partner_i(partner_i), .event_i(event_i),
    .ctrl_o(ctrl_o), .adv_o(adv_o), .irq_o(irq_o)
  );
endmodule

// File: tb/test_mdio_slave.sv
`timescale 1ns/1ps
module test_mdio_slave;
  localparam logic [4:0]  PHY  = 5'h0B;
  localparam logic [4:0]  OTH  = 5'h0C;
  localparam logic [15:0] STAT = 16'h782D;
  localparam logic [15:0] PART = 16'h45E1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_drv = 1'b1;
  logic [15:0] event_in = '0;
  logic mdio_o, mdio_oe;
  logic [15:0] ctrl, adv;
  logic irq;
  logic line;
  int checks = 0, fails = 0;

  assign line = mdio_oe ? mdio_o : m_drv;
  always #5 clk = ~clk;

  mdio_slave i_mdio_slave (
    .mdc_i(clk), .rst_ni(rst_n), .mdio_i(line), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe),
    .phy_addr_i(PHY), .status_i(STAT), .partner_i(PART), .event_i(event_in),
    .ctrl_o(ctrl), .adv_o(adv), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    m_drv = b;
  endtask

  task automatic header(input int pre_n, input logic [1:0] st, input logic [1:0] op,
                        input logic [4:0] phy, input logic [4:0] ra);
    for (int i = 0; i < pre_n; i++) send_bit(1'b1);
    for (int i = 1; i >= 0; i--) send_bit(st[i]);
    for (int i = 1; i >= 0; i--) send_bit(op[i]);
    for (int i = 4; i >= 0; i--) send_bit(phy[i]);
    for (int i = 4; i >= 0; i--) send_bit(ra[i]);
  endtask

  task automatic wr_frame(input int pre_n, input logic [1:0] st, input logic [1:0] op,
                          input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d);
    header(pre_n, st, op, phy, ra);
    send_bit(1'b1);
    send_bit(1'b0);
    for (int i = 15; i >= 0; i--) send_bit(d[i]);
    send_bit(1'b1);
  endtask

  // Returns data, ta_ok (released in TA1, driving 0 in TA2, released after), any_oe
  task automatic rd_frame(input logic [4:0] phy, input logic [4:0] ra,
                          output logic [15:0] d, output logic ta_ok, output logic any_oe);
    logic ta1, ta2, tail;
    header(32, 2'b01, 2'b10, phy, ra);
    @(negedge clk); m_drv = 1'b1;
    ta1 = mdio_oe;
    any_oe = mdio_oe;
    @(negedge clk);
    ta2 = mdio_oe && (line == 1'b0);
    any_oe |= mdio_oe;
    d = '0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      d = {d[14:0], line};
      any_oe |= mdio_oe;
    end
    @(negedge clk);
    tail = mdio_oe;
    ta_ok = !ta1 && ta2 && !tail;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 oe", {15'd0, mdio_oe}, 16'd0);
    chk("R1 irq", {15'd0, irq}, 16'd0);
    chk("R1 ctrl", ctrl, 16'h3000);
    chk("R1 adv", adv, 16'h01E1);
  endtask

  task automatic t_read_map;
    logic [15:0] d; logic ok, oe;
    rd_frame(PHY, 5'd2, d, ok, oe);
    chk("R8 id_hi", d, 16'h0A5C);
    chk("R5 turnaround", {15'd0, ok}, 16'd1);
    rd_frame(PHY, 5'd3, d, ok, oe); chk("R8 id_lo", d, 16'h3E11);
    rd_frame(PHY, 5'd1, d, ok, oe); chk("R8 status", d, STAT);
    rd_frame(PHY, 5'd5, d, ok, oe); chk("R8 partner", d, PART);
    rd_frame(PHY, 5'd7, d, ok, oe); chk("R8 unmapped", d, 16'h0000);
    chk("R6 release", {15'd0, ok}, 16'd1);
    rd_frame(PHY, 5'd19, d, ok, oe); chk("R1 mask reset", d, 16'hFFFF);
  endtask

  task automatic t_write;
    logic [15:0] d; logic ok, oe;
    wr_frame(32, 2'b01, 2'b01, PHY, 5'd0, 16'hA5C3);
    chk("R4 ctrl write", ctrl, 16'hA5C3);
    rd_frame(PHY, 5'd0, d, ok, oe); chk("R6 ctrl readback", d, 16'hA5C3);
    wr_frame(32, 2'b01, 2'b01, PHY, 5'd4, 16'h5E3A);
    chk("R4 adv write", adv, 16'h5E3A);
    wr_frame(32, 2'b01, 2'b01, PHY, 5'd1, 16'h0000);
    rd_frame(PHY, 5'd1, d, ok, oe); chk("R8 status read-only", d, STAT);
  endtask

  task automatic t_short_preamble;
    send_bit(1'b0);
    wr_frame(31, 2'b01, 2'b01, PHY, 5'd0, 16'h1111);
    chk("R2 short preamble ignored", ctrl, 16'hA5C3);
    wr_frame(32, 2'b01, 2'b01, PHY, 5'd0, 16'h2222);
    chk("R2 full preamble accepted", ctrl, 16'h2222);
  endtask

  task automatic t_bad_codes;
    wr_frame(32, 2'b00, 2'b01, PHY, 5'd0, 16'h3333);
    chk("R3 bad start", ctrl, 16'h2222);
    wr_frame(32, 2'b01, 2'b11, PHY, 5'd0, 16'h4444);
    chk("R3 opcode 11", ctrl, 16'h2222);
    wr_frame(32, 2'b01, 2'b00, PHY, 5'd0, 16'h5555);
    chk("R3 opcode 00", ctrl, 16'h2222);
  endtask

  task automatic t_back_to_back;
    wr_frame(32, 2'b01, 2'b01, PHY, 5'd0, 16'h6666);
    wr_frame(0, 2'b01, 2'b01, PHY, 5'd0, 16'h0F0F);
    chk("R11 no preamble ignored", ctrl, 16'h6666);
  endtask

  task automatic t_mismatch;
    logic [15:0] d; logic ok, oe;
    wr_frame(32, 2'b01, 2'b01, OTH, 5'd0, 16'h7777);
    chk("R7 no write", ctrl, 16'h6666);
    rd_frame(OTH, 5'd0, d, ok, oe);
    chk("R7 never drives", {15'd0, oe}, 16'd0);
  endtask

  task automatic t_interrupts;
    logic [15:0] d; logic ok, oe;
    @(negedge clk); event_in = 16'h0008;
    @(negedge clk); event_in = 16'h0000;
    chk("R10 masked", {15'd0, irq}, 16'd0);
    wr_frame(32, 2'b01, 2'b01, PHY, 5'd19, 16'h0000);
    chk("R10 unmasked irq", {15'd0, irq}, 16'd1);
    rd_frame(OTH, 5'd18, d, ok, oe);
    chk("R7 no clear on mismatch", {15'd0, irq}, 16'd1);
    rd_frame(PHY, 5'd18, d, ok, oe);
    chk("R9 latched value", d, 16'h0008);
    chk("R9 cleared", {15'd0, irq}, 16'd0);
    @(negedge clk); event_in = 16'h0020;
    rd_frame(PHY, 5'd18, d, ok, oe);
    chk("R9 event during read", d, 16'h0020);
    chk("R9 kept set", {15'd0, irq}, 16'd1);
    event_in = 16'h0000;
    rd_frame(PHY, 5'd18, d, ok, oe);
    chk("R9 survives read", d, 16'h0020);
    chk("R9 cleared after", {15'd0, irq}, 16'd0);
    wr_frame(32, 2'b01, 2'b01, PHY, 5'd19, 16'h0040);
    @(negedge clk); event_in = 16'h0040;
    @(negedge clk); event_in = 16'h0000;
    chk("R10 masked bit", {15'd0, irq}, 16'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_read_map;
    t_write;
    t_short_preamble;
    t_bad_codes;
    t_back_to_back;
    t_mismatch;
    t_interrupts;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule